// File: doc/BRIEF.md
# Indirect Configuration Memory Access Port

This block gives a host byte access to a 512-byte internal configuration memory through three registers on a simple register bus. The memory is laid out as 32 records of 16 bytes. Two of the registers hold a 9-bit byte pointer. The low register holds bits 7:0 and bit 0 of the high register holds bit 8. The third register is a data window. Each data-window read or write reaches the byte that the pointer selects, and the pointer then moves on by one. A host loads the pointer at the first byte of a record and streams bytes from there, so it can rewrite only the records it cares about.

Memory traffic is allowed only while the `unlock` input is high. Outside logic drives `unlock` when the related mode registers sit in the state that permits configuration access. While the port is locked, the pointer registers still work. Data-window traffic is then refused: writes are dropped, reads return zero and the pointer holds.

Top module: `cfg_ram_port`

## Requirements
- R1: After reset, `rdata` is 0xDC and the pointer is 0x00F, so the low register reads 0x0F and the high register reads 0x00.
- R2: A write to offset 0x01 loads pointer bits 7:0 from `wdata`. A read of offset 0x01 returns the current pointer bits 7:0.
- R3: A write to offset 0x02 loads pointer bit 8 from `wdata[0]` and ignores `wdata[7:1]`. A read of offset 0x02 returns pointer bit 8 in bit 0, with bits 7:1 at zero.
- R4: While `unlock` is high, a write to offset 0x00 stores `wdata` at the pointed byte and then adds one to the pointer.
- R5: While `unlock` is high, a read of offset 0x00 returns the pointed byte on `rdata` in the cycle after `rd_en`, and then adds one to the pointer.
- R6: The pointer wraps from 0x1FF to 0x000 when it advances.
- R7: While `unlock` is low, data-window writes leave the memory unchanged, data-window reads return 0x00, and the pointer does not move.
- R8: A read of any offset other than 0x00, 0x01 or 0x02 returns 0x00 and does not move the pointer.
- R9: When `wr_en` and `rd_en` are high in the same cycle, only the write takes place and `rdata` keeps its previous value.
- R10: While `wr_en` and `rd_en` are both low, the pointer and `rdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| unlock | input | 1 | High while memory access is permitted |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The bench streams records through the data window and reads them back. It checks the pointer after each burst, so a design that failed to advance after reads would return the same byte again and again. The pointer is parked at 0x1FF before two writes. A design without the wrap would write past the memory or stall at the top byte. Locked accesses are followed by a pointer readback and, once unlocked, by a read of the byte that was targeted. Any leak of a locked write or a locked advance therefore shows up as a wrong value. The bench also sends a cycle with both strobes high and writes junk into the upper bits of the high register. A design that let the read through would change `rdata`, and one that kept the junk bits would read back a nonzero value.

// File: rtl/cfg_ram_port.sv
module cfg_ram_port #(
  parameter int RECORDS   = 32,
  parameter int REC_BYTES = 16,
  parameter int DW        = 8,
  parameter logic [7:0] OFS_DATA = 8'h00,
  parameter logic [7:0] OFS_LO   = 8'h01,
  parameter logic [7:0] OFS_HI   = 8'h02,
  parameter logic [7:0] RST_DATA = 8'hDC,
  parameter int RST_PTR   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          unlock,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = RECORDS * REC_BYTES;
  localparam int PW    = $clog2(DEPTH);
  localparam int HW    = PW - 8;

  logic [PW-1:0] ptr;
  logic [DW-1:0] mem [DEPTH];

  wire hit_d  = addr == OFS_DATA;
  wire hit_lo = addr == OFS_LO;
  wire hit_hi = addr == OFS_HI;
  wire rd_any = rd_en & ~wr_en;
  wire do_wr  = wr_en & hit_d & unlock;
  wire do_rd  = rd_any & hit_d & unlock;

  always_ff @(posedge clk)
    if (do_wr) mem[ptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ptr <= PW'(RST_PTR);
    else if (do_wr || do_rd)   ptr <= ptr + PW'(1);
    else if (wr_en && hit_lo)  ptr[7:0] <= wdata[7:0];
    else if (wr_en && hit_hi)  ptr[PW-1:8] <= wdata[HW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= RST_DATA;
    else if (rd_any) begin
      if (hit_d)       rdata <= unlock ? mem[ptr] : '0;
      else if (hit_lo) rdata <= DW'(ptr[7:0]);
      else if (hit_hi) rdata <= DW'(ptr[PW-1:8]);
      else             rdata <= '0;
    end
endmodule

module cfg_ram_port_chk #(
  parameter int PW = 9,
  parameter int DW = 8,
  parameter logic [7:0] OFS_DATA = 8'h00,
  parameter logic [7:0] OFS_LO   = 8'h01,
  parameter logic [7:0] OFS_HI   = 8'h02
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic          rd_en,
  input logic          unlock,
  input logic [DW-1:0] rdata,
  input logic [PW-1:0] ptr
);
  // R4
  win_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr == OFS_DATA && unlock) |=> ptr == $past(ptr) + PW'(1));
  // R7
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr == OFS_DATA && !unlock) |=> $stable(ptr));
  // R7
  locked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == OFS_DATA && !unlock) |=> rdata == '0);
  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LO) |=> ptr[7:0] == $past(wdata[7:0]));
  // R3
  hi_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == OFS_HI) |=> rdata[DW-1:PW-8] == '0);
  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rdata));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> ($stable(ptr) && $stable(rdata)));
  // R8
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr != OFS_DATA && addr != OFS_LO && addr != OFS_HI)
      |=> (rdata == '0 && $stable(ptr)));
endmodule

bind cfg_ram_port cfg_ram_port_chk #(
  .PW(PW), .DW(DW), .OFS_DATA(OFS_DATA), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .unlock(unlock), .rdata(rdata), .ptr(ptr)
);

// File: tb/cfg_ram_port_tb.sv
`timescale 1ns/1ps
module cfg_ram_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic wr_en = 0, rd_en = 0, unlock = 1;
  always #2 clk = ~clk;

  cfg_ram_port dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .unlock(unlock), .rdata(rdata));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [512];
  logic [8:0] bp;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    if (rst_n && rd_en && !wr_en) begin
      @(negedge clk);
      if (exp_q.size() > 0) check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask
  task automatic set_ptr(input logic [8:0] p);
    wr(8'h01, p[7:0]); wr(8'h02, {7'b0, p[8]}); bp = p;
  endtask
  task automatic win_wr(input logic [7:0] d);
    wr(8'h00, d); model[bp] = d; bp = bp + 9'd1;
  endtask
  task automatic win_rd(input string tag);
    rd(8'h00, model[bp], tag); bp = bp + 9'd1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] hold;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check(rdata, 8'hDC, "R1 rdata");
    rd(8'h01, 8'h0F, "R1 lo");
    rd(8'h02, 8'h00, "R1 hi");

    set_ptr(9'h000);
    for (int i = 0; i < 16; i++) win_wr(8'(8'h30 + i * 7));
    rd(8'h01, 8'h10, "R4 ptr after writes");
    set_ptr(9'h000);
    for (int i = 0; i < 16; i++) win_rd("R5 readback");
    rd(8'h01, 8'h10, "R5 ptr after reads");

    wr(8'h01, 8'h20); wr(8'h02, 8'hFF); bp = 9'h120;
    rd(8'h02, 8'h01, "R3 hi bit only");
    rd(8'h01, 8'h20, "R2 lo readback");
    win_wr(8'h5A); win_wr(8'hC3);
    set_ptr(9'h120);
    win_rd("R5 upper half"); win_rd("R5 upper half");

    set_ptr(9'h1FF);
    win_wr(8'hAA); win_wr(8'hBB);
    rd(8'h01, 8'h01, "R6 wrap lo");
    rd(8'h02, 8'h00, "R6 wrap hi");
    set_ptr(9'h1FF);
    win_rd("R6 top byte"); win_rd("R6 wrapped byte");

    unlock = 0;
    set_ptr(9'h005);
    wr(8'h00, 8'h77);
    rd(8'h00, 8'h00, "R7 locked read");
    rd(8'h01, 8'h05, "R7 ptr held");
    unlock = 1;
    win_rd("R7 memory unchanged");

    rd(8'h40, 8'h00, "R8 unmapped");
    rd(8'h01, 8'h06, "R8 ptr held");

    set_ptr(9'h008);
    win_rd("R5 before dual");
    hold = rdata;
    addr = 8'h00; wdata = 8'hE1; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    check(rdata, hold, "R9 rdata held");
    model[9'h009] = 8'hE1;
    @(negedge clk); @(negedge clk);
    check(rdata, hold, "R10 idle hold");
    set_ptr(9'h009);
    win_rd("R9 write applied");

    @(negedge clk); @(negedge clk);
    check(8'(exp_q.size()), 8'h00, "scoreboard drained");
    finish_run();
  end
endmodule